// File: doc/BRIEF.md
# Vectored Interrupt Controller with Global Mask

This block arbitrates four interrupt sources for a small 8-bit processor core. Two external pins each raise a request on one selectable edge. A timer overflow pulse raises a third request. A fourth request comes from either of two converter-timer overflow pulses. Each request is latched into a flag bit. The flag bits and the per-source enables, together with a global enable, sit in two byte-wide control registers. Software writes these registers over a simple write strobe and can always read them back on two read buses.

The controller raises `irq_req` when a qualified request is pending and presents the vector address of the winning source. When the core acknowledges, the controller clears the winning flag and the global enable in the same update, so the service routine is masked by default. A return-from-interrupt strobe sets the global enable again. A plain return strobe leaves it unchanged. A stack-full input blocks every request, so an acknowledge is never asked for while the core cannot push its program counter. Software may set the global enable during service to allow nesting.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset both control registers read 0x00 and `irq_req` is low.
- R2: Register 0 holds these fields: bit 0 global enable; bits 1, 2 and 3 enable external 0, external 1 and timer; bits 4, 5 and 6 are the flags of external 0, external 1 and timer; bit 7 reads 0. Register 1 holds the converter enable in bit 0 and the converter flag in bit 4, and every other bit reads 0. A write with `reg_sel`=0 targets register 0, and a write with `reg_sel`=1 targets register 1. Both registers are readable and writable.
- R3: A source event sets its flag on the next clock edge whatever the enables, the global enable or service state. A pulse on either converter overflow input sets the converter flag.
- R4: When `ext_rise_sel[i]` is 1, external pin i flags on a rising edge; when it is 0, the pin flags on a falling edge. The opposite edge does not set the flag.
- R5: `irq_req` is high in the same cycle exactly when some source has its flag and its enable set, the global enable is 1 and `stack_full` is 0.
- R6: `irq_vector` is 0x04 for external 0, 0x08 for external 1, 0x0C for the timer and 0x10 for the converter. Among qualified sources the lowest vector wins.
- R7: `irq_ack` while `irq_req` is high clears the winning flag and the global enable on the next edge. Other flags are left as they are. `irq_ack` while `irq_req` is low has no effect.
- R8: `reti` sets the global enable on the next edge. `ret` has no effect on any register.
- R9: If a hardware event and a software write to the same flag fall in the same cycle, the flag ends up set.
- R10: During service, software can set the global enable. A qualified pending request then raises `irq_req` again with its vector, and `stack_full` still blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 2 | External interrupt pins |
| ext_rise_sel | input | 2 | Static edge choice per pin, 1 = rising, 0 = falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| cvt_a_ovf | input | 1 | Converter timer A overflow pulse |
| cvt_b_ovf | input | 1 | Converter timer B overflow pulse |
| stack_full | input | 1 | Core stack full, blocks requests |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select, 0 or 1 |
| reg_wdata | input | 8 | Write data |
| ctl0_rdata | output | 8 | Register 0 read value |
| ctl1_rdata | output | 8 | Register 1 read value |
| irq_req | output | 1 | Interrupt should be taken |
| irq_vector | output | 8 | Vector address of the winning source |
| irq_ack | input | 1 | Core acknowledges the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| ret | input | 1 | Plain return strobe |

## Verification
Every bit of state in this block can be read on the two register read buses one cycle after it changes. A stale or wrongly cleared flag, or a global enable that is wrong, therefore shows up at the ports on the first read after the faulty edge. The request and vector outputs are combinational from that state. So a wrong arbitration choice or a missed stack-full block appears in the same cycle as the stimulus, and a wrong clear appears after the next edge, when a different vector or a dropped request shows.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NUM_SRC  = 4;
    localparam int NUM_EXT  = 2;
    localparam int REG_W    = 8;
    localparam int SRC_E0   = 0;
    localparam int SRC_E1   = 1;
    localparam int SRC_TM   = 2;
    localparam int SRC_RC   = 3;
    // register 0 field positions
    localparam int R0_GIE   = 0;
    localparam int R0_EN_LO = 1;
    localparam int R0_FL_LO = 4;
    // register 1 field positions
    localparam int R1_EN    = 0;
    localparam int R1_FL    = 4;

    typedef struct packed {
        logic               gie;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] flag;
    } irq_state_t;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
        edge_o = rise_sel ? (pin & ~prev_q) : (~pin & prev_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= ~rise_sel;
        else        prev_q <= prev_d;
    end

    // R4: an edge report requires the pin to sit at the selected active level now
    p_edge_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (pin == rise_sel));
    // R4: an edge report needs the pin at the opposite level in the cycle before
    p_edge_prior_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (prev_q != pin));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N        = 4,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pending,
    output logic             valid,
    output logic [N-1:0]     grant,
    output logic [VEC_W-1:0] vector
);
    always_comb begin
        grant  = '0;
        vector = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                vector = VEC_W'(VEC_BASE + VEC_STEP * i);
            end
        end
        valid = |pending;
    end

    // R6: at most one source is granted
    p_one_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6: a grant exists whenever something is pending
    p_grant_when_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> (grant != '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EXT-1:0] ext_rise_sel,
    input  logic               tmr_ovf,
    input  logic               cvt_a_ovf,
    input  logic               cvt_b_ovf,
    input  logic               stack_full,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   ctl0_rdata,
    output logic [REG_W-1:0]   ctl1_rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector,
    input  logic               irq_ack,
    input  logic               reti,
    input  logic               ret
);
    localparam int R0_SRCS = NUM_SRC - 1;

    irq_state_t st_d, st_q;
    logic [NUM_SRC-1:0] src_evt;
    logic [NUM_SRC-1:0] qualified;
    logic [NUM_SRC-1:0] grant;
    logic               any_q;
    logic               take_ack;

    genvar g;
    generate
        for (g = 0; g < NUM_EXT; g++) begin : g_ext
            irq_edge_det u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (ext_pin[g]),
                .rise_sel (ext_rise_sel[g]),
                .edge_o   (src_evt[g])
            );
        end
    endgenerate

    assign src_evt[SRC_TM] = tmr_ovf;
    assign src_evt[SRC_RC] = cvt_a_ovf | cvt_b_ovf;

    assign qualified = (st_q.gie && !stack_full) ? (st_q.flag & st_q.en) : '0;

    irq_prio_arb #(
        .N        (NUM_SRC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (qualified),
        .valid   (any_q),
        .grant   (grant),
        .vector  (irq_vector)
    );

    assign irq_req  = any_q;
    assign take_ack = irq_ack & any_q;

    always_comb begin
        ctl0_rdata = '0;
        ctl0_rdata[R0_GIE] = st_q.gie;
        ctl0_rdata[R0_EN_LO +: R0_SRCS] = st_q.en[R0_SRCS-1:0];
        ctl0_rdata[R0_FL_LO +: R0_SRCS] = st_q.flag[R0_SRCS-1:0];
        ctl1_rdata = '0;
        ctl1_rdata[R1_EN] = st_q.en[SRC_RC];
        ctl1_rdata[R1_FL] = st_q.flag[SRC_RC];
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            if (!reg_sel) begin
                st_d.gie = reg_wdata[R0_GIE];
                st_d.en[R0_SRCS-1:0]   = reg_wdata[R0_EN_LO +: R0_SRCS];
                st_d.flag[R0_SRCS-1:0] = reg_wdata[R0_FL_LO +: R0_SRCS];
            end else begin
                st_d.en[SRC_RC]   = reg_wdata[R1_EN];
                st_d.flag[SRC_RC] = reg_wdata[R1_FL];
            end
        end
        if (reti) st_d.gie = 1'b1;
        if (take_ack) begin
            st_d.gie  = 1'b0;
            st_d.flag = st_d.flag & ~grant;
        end
        st_d.flag = st_d.flag | src_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: stack full blocks any request
    p_stack_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full |-> !irq_req);
    // R5: no request while the global enable reads 0
    p_gie_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_rdata[R0_GIE] |-> !irq_req);
    // R7: a taken acknowledge leaves the global enable cleared
    p_ack_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !ctl0_rdata[R0_GIE]);
    // R8: a return-from-interrupt without an acknowledge enables globally
    p_reti_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq_ack && irq_req)) |=> ctl0_rdata[R0_GIE]);
    // R3: timer and converter events always latch
    p_tmr_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctl0_rdata[R0_FL_LO + SRC_TM]);
    p_cvt_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cvt_a_ovf || cvt_b_ovf) |=> ctl1_rdata[R1_FL]);
    // R2: unused bits stay zero
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl0_rdata[7] && (ctl1_rdata & 8'hEE) == 8'h00);
    // R6: the vector is one of the four legal addresses when requesting
    p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vector == VEC_W'(VEC_BASE) ||
                     irq_vector == VEC_W'(VEC_BASE + VEC_STEP) ||
                     irq_vector == VEC_W'(VEC_BASE + 2*VEC_STEP) ||
                     irq_vector == VEC_W'(VEC_BASE + 3*VEC_STEP)));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ext_pin;
    logic [1:0] ext_rise_sel;
    logic       tmr_ovf, cvt_a_ovf, cvt_b_ovf, stack_full;
    logic       reg_wr, reg_sel;
    logic [7:0] reg_wdata;
    logic [7:0] ctl0_rdata, ctl1_rdata, irq_vector;
    logic       irq_req, irq_ack, reti, ret;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_sel(ext_rise_sel),
        .tmr_ovf(tmr_ovf), .cvt_a_ovf(cvt_a_ovf), .cvt_b_ovf(cvt_b_ovf),
        .stack_full(stack_full), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctl0_rdata(ctl0_rdata), .ctl1_rdata(ctl1_rdata),
        .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack),
        .reti(reti), .ret(ret)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1; step(); irq_ack = 1'b0; #1;
    endtask

    task automatic do_reti();
        reti = 1'b1; step(); reti = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R1 ctl0", ctl0_rdata, 8'h00);
        chk("R1 ctl1", ctl1_rdata, 8'h00);
        chk("R1 req", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_regs();
        wr(1'b0, 8'hFF); chk("R2 ctl0 all ones", ctl0_rdata, 8'h7F);
        wr(1'b1, 8'hFF); chk("R2 ctl1 all ones", ctl1_rdata, 8'h11);
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        chk("R2 ctl0 cleared", ctl0_rdata, 8'h00);
        chk("R2 ctl1 cleared", ctl1_rdata, 8'h00);
    endtask

    task automatic t_latch();
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        chk("R3 timer flag", ctl0_rdata, 8'h40);
        chk("R3 no req while disabled", {7'd0, irq_req}, 8'h00);
        cvt_b_ovf = 1'b1; step(); cvt_b_ovf = 1'b0;
        chk("R3 converter B", ctl1_rdata, 8'h10);
        wr(1'b1, 8'h00);
        cvt_a_ovf = 1'b1; step(); cvt_a_ovf = 1'b0;
        chk("R3 converter A", ctl1_rdata, 8'h10);
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    endtask

    task automatic t_edges();
        ext_pin[0] = 1'b0; step();
        chk("R4 pin0 falling sets", ctl0_rdata, 8'h10);
        wr(1'b0, 8'h00);
        ext_pin[0] = 1'b1; step(); step();
        chk("R4 pin0 rising ignored", ctl0_rdata, 8'h00);
        ext_pin[1] = 1'b1; step();
        chk("R4 pin1 rising sets", ctl0_rdata, 8'h20);
        wr(1'b0, 8'h00);
        ext_pin[1] = 1'b0; step(); step();
        chk("R4 pin1 falling ignored", ctl0_rdata, 8'h00);
    endtask

    task automatic t_qualify();
        wr(1'b0, 8'h48);
        chk("R5 no req without gie", {7'd0, irq_req}, 8'h00);
        wr(1'b0, 8'h49); #1;
        chk("R5 req qualified", {7'd0, irq_req}, 8'h01);
        chk("R6 timer vector", irq_vector, 8'h0C);
        stack_full = 1'b1; #1;
        chk("R5 stack full blocks", {7'd0, irq_req}, 8'h00);
        stack_full = 1'b0; #1;
        wr(1'b0, 8'h41); #1;
        chk("R5 no req with source disabled", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_priority();
        wr(1'b1, 8'h11); wr(1'b0, 8'h7F); #1;
        chk("R6 ext0 wins", irq_vector, 8'h04);
        do_ack();
        chk("R7 ack clears ext0 flag and gie", ctl0_rdata, 8'h6E);
        chk("R7 req dropped", {7'd0, irq_req}, 8'h00);
        do_reti();
        chk("R8 reti sets gie", ctl0_rdata, 8'h6F);
        chk("R6 ext1 next", irq_vector, 8'h08);
        do_ack();
        chk("R7 ack clears ext1", ctl0_rdata, 8'h4E);
        do_reti();
        chk("R6 timer next", irq_vector, 8'h0C);
        do_ack();
        chk("R7 ack clears timer", ctl0_rdata, 8'h0E);
        do_reti();
        chk("R6 converter last", irq_vector, 8'h10);
        do_ack();
        chk("R7 ack clears converter", ctl1_rdata, 8'h01);
        chk("R7 ctl0 after converter ack", ctl0_rdata, 8'h0E);
        wr(1'b0, 8'h4E);
        do_ack();
        chk("R7 ack ignored without req", ctl0_rdata, 8'h4E);
    endtask

    task automatic t_ret();
        ret = 1'b1; step(); ret = 1'b0;
        chk("R8 ret has no effect", ctl0_rdata, 8'h4E);
        chk("R8 ret leaves ctl1", ctl1_rdata, 8'h01);
        do_reti();
        chk("R8 reti enables", ctl0_rdata, 8'h4F);
    endtask

    task automatic t_hw_wins();
        wr(1'b1, 8'h00);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        step();
        reg_wr = 1'b0; tmr_ovf = 1'b0;
        chk("R9 hw set beats write reg0", ctl0_rdata, 8'h40);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h00; cvt_a_ovf = 1'b1;
        step();
        reg_wr = 1'b0; cvt_a_ovf = 1'b0;
        chk("R9 hw set beats write reg1", ctl1_rdata, 8'h10);
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);
    endtask

    task automatic t_nest();
        wr(1'b0, 8'h2F); #1;
        chk("R10 ext1 vector", irq_vector, 8'h08);
        do_ack();
        chk("R10 in service", ctl0_rdata, 8'h0E);
        ext_pin[0] = 1'b0; step(); #1;
        chk("R3 latch during service", ctl0_rdata, 8'h1E);
        chk("R10 masked during service", {7'd0, irq_req}, 8'h00);
        wr(1'b0, 8'h1F); #1;
        chk("R10 nested req", {7'd0, irq_req}, 8'h01);
        chk("R10 nested vector", irq_vector, 8'h04);
        stack_full = 1'b1; #1;
        chk("R10 nested blocked by stack", {7'd0, irq_req}, 8'h00);
        stack_full = 1'b0;
        ext_pin[0] = 1'b1; step();
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        ext_rise_sel = 2'b10;
        ext_pin = 2'b01;
        tmr_ovf = 1'b0; cvt_a_ovf = 1'b0; cvt_b_ovf = 1'b0; stack_full = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 8'h00;
        irq_ack = 1'b0; reti = 1'b0; ret = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_latch();
        t_edges();
        t_qualify();
        t_priority();
        t_ret();
        t_hw_wins();
        t_nest();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule